// File: doc/BRIEF.md
# Clock-Source Switch Settling Sequencer

This block owns a free-running timebase counter and uses it to pace changes of the active clock source. Three sources are modelled: the main oscillator, the PLL and the sub oscillator. Two request bits select the wanted source. When the source changes, the block waits until the oscillator that the new source depends on has had time to settle. The wait starts from a counter value of zero and ends on the carry out of a counter bit chosen by a 2-bit tap select. Software can force the counter back to zero with a one-cycle clear strobe.

A power-up reset holds the block in a wait. Clocks are off during this wait, and when it ends the main source is active. The other reset causes leave the block alone. Leaving the PLL takes effect at once. Every other switch first runs a settling wait. A switch from sub to PLL waits on the main oscillator, because the PLL runs from it. While a wait runs, the busy flag is high and new requests are held until the wait ends. The active source is a registered 2-bit output; the glitch-free multiplexing itself lies outside the block.

Top module: `osc_settle_seq`

## Requirements
- R1: While `rst_n` is low, `clk_mode` reads 2'b11 (no clock), `settling` is 1 and `tb_count` is 0.
- R2: `tb_count` increases by one on every clock edge where `tb_clr` is low, and wraps at 2^CNT_W.
- R3: A clock edge that sees `tb_clr` high loads `tb_count` with 0, whether or not a wait is running.
- R4: `tap_sel` values 0, 1, 2 and 3 pick counter bit TAP0, TAP1, TAP2 and TAP3. A wait that starts with the counter at zero on edge 0 changes `clk_mode` and drops `settling` on edge 2^(TAP+1)+1. That is one edge after the carry out of the picked bit.
- R5: Releasing `rst_n`, or a `rst_cause_vld` strobe with `rst_cause` = 0 (power-up), starts a wait with `clk_mode` = 2'b11. When the wait ends, `clk_mode` = 2'b00 (main).
- R6: A `rst_cause_vld` strobe with `rst_cause` 1 to 6 does not change `clk_mode`, `settling` or the counter sequence.
- R7: The requested source is sub (2'b10) when `req_fast` = 0. Otherwise it is main (2'b00) when `req_main` = 1, and PLL (2'b01) when `req_main` = 0. A change from main to PLL enters PLL only after a full settling wait.
- R8: A change from main to sub, and a change from sub to main, each take effect only after a full settling wait.
- R9: A change from sub to PLL enters PLL only after a full settling wait, timed like a wait on the main oscillator.
- R10: A change from PLL to main or from PLL to sub appears on `clk_mode` at the next edge. `settling` stays 0 and the counter is not cleared.
- R11: Request changes made during a wait do not alter the source entered at the end of that wait. A request still pending is acted on from the next cycle.
- R12: A `tb_clr` strobe during a wait restarts the wait, with the clearing edge counted as edge 0.
- R13: The edge that starts a settling wait also loads `tb_count` with 0 and raises `settling`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-up reset, asynchronous |
| rst_cause_vld | input | 1 | One-cycle strobe marking a reset event |
| rst_cause | input | 3 | Reset cause code: 0 power-up, 1 to 6 other causes |
| req_main | input | 1 | Requested fast source: 1 main, 0 PLL |
| req_fast | input | 1 | Requested side: 1 main/PLL, 0 sub |
| tb_clr | input | 1 | Software strobe that clears the timebase counter |
| tap_sel | input | 2 | Chooses the counter bit whose carry ends a wait |
| clk_mode | output | 2 | Active source: 00 main, 01 PLL, 10 sub, 11 none |
| settling | output | 1 | High while a settling wait is running |
| tb_count | output | CNT_W | Timebase counter value |

## Verification
A counter that skips or fails to clear shows up on `tb_count` on the very next edge. A fault in the carry tap or its register moves the fall of `settling` and the change of `clk_mode` by at least one cycle. The bench checks that edge on both sides. A wrong pending target or a missing hold shows up as the wrong `clk_mode` code on the first cycle after a wait. A wait wrongly taken or skipped on a switch shows up as `settling` in the cycle right after the request.

// File: rtl/osc_settle_pkg.sv
package osc_settle_pkg;

   localparam int unsigned NUM_TAPS  = 4;
   localparam int unsigned TAP_SEL_W = $clog2(NUM_TAPS);
   localparam int unsigned CAUSE_W   = 3;

   localparam logic [CAUSE_W-1:0] CAUSE_POWERUP = 3'd0;

   typedef enum logic [1:0] {
      CLK_MAIN = 2'b00,
      CLK_PLL  = 2'b01,
      CLK_SUB  = 2'b10,
      CLK_OFF  = 2'b11
   } clk_mode_e;

   function automatic clk_mode_e decode_request(input logic want_main, input logic want_fast);
      if (!want_fast)
         return CLK_SUB;
      else if (want_main)
         return CLK_MAIN;
      else
         return CLK_PLL;
   endfunction

   // Leaving the PLL never waits: main stays powered while the PLL runs,
   // and the sub oscillator keeps running in every mode.
   function automatic logic needs_settle(input clk_mode_e src, input clk_mode_e dst);
      logic w;
      w = 1'b0;
      if (src != dst) begin
         case (src)
            CLK_PLL:  w = 1'b0;
            CLK_MAIN: w = 1'b1;
            CLK_SUB:  w = 1'b1;
            default:  w = 1'b1;
         endcase
      end
      return w;
   endfunction

endpackage

// File: rtl/osc_timebase.sv
module osc_timebase
   import osc_settle_pkg::*;
#(
   parameter int unsigned CNT_W = 18,
   parameter int unsigned TAP0  = 9,
   parameter int unsigned TAP1  = 13,
   parameter int unsigned TAP2  = 15,
   parameter int unsigned TAP3  = 17
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic [TAP_SEL_W-1:0] tap_sel,
   output logic [CNT_W-1:0]     count,
   output logic                 carry
);

   function automatic int unsigned tap_at(input int unsigned idx);
      case (idx)
         0:       return TAP0;
         1:       return TAP1;
         2:       return TAP2;
         default: return TAP3;
      endcase
   endfunction

   logic [CNT_W-1:0]    cnt_q;
   logic                carry_q;
   logic [NUM_TAPS-1:0] tap_full;

   if (CNT_W < 2) begin : g_bad_width
      $error("osc_timebase: CNT_W must be at least 2");
   end

   for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
      localparam int unsigned POS = tap_at(g);
      if (POS >= CNT_W) begin : g_bad_pos
         $error("osc_timebase: tap position beyond counter width");
      end else begin : g_ok
         assign tap_full[g] = &cnt_q[POS:0];
      end
      if (g > 0) begin : g_order
         localparam int unsigned PREV = tap_at(g - 1);
         if (POS <= PREV) begin : g_bad_order
            $error("osc_timebase: tap positions must rise with the select code");
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         carry_q <= 1'b0;
      end else if (clr) begin
         cnt_q   <= '0;
         carry_q <= 1'b0;
      end else begin
         cnt_q   <= cnt_q + 1'b1;
         carry_q <= tap_full[tap_sel];
      end
   end

   assign count = cnt_q;
   assign carry = carry_q;

   assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> count == CNT_W'($past(count) + 1'b1));

   assert_count_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> count == '0);

   assert_carry_needs_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
      carry |-> !$past(clr));

endmodule

// File: rtl/osc_mode_plan.sv
module osc_mode_plan
   import osc_settle_pkg::*;
(
   input  clk_mode_e active,
   input  logic      req_main,
   input  logic      req_fast,
   output clk_mode_e target,
   output logic      differ,
   output logic      need_wait
);

   always_comb begin
      target    = decode_request(req_main, req_fast);
      differ    = (target != active);
      need_wait = needs_settle(active, target);
   end

endmodule

// File: rtl/osc_settle_ctl.sv
module osc_settle_ctl
   import osc_settle_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      por_evt,
   input  logic      carry,
   input  clk_mode_e target,
   input  logic      differ,
   input  logic      need_wait,
   output clk_mode_e mode,
   output logic      busy,
   output logic      start
);

   clk_mode_e mode_q, mode_d;
   clk_mode_e pend_q, pend_d;
   logic      busy_q, busy_d;

   always_comb begin
      start  = 1'b0;
      mode_d = mode_q;
      pend_d = pend_q;
      busy_d = busy_q;
      if (por_evt) begin
         start  = 1'b1;
         mode_d = CLK_OFF;
         pend_d = CLK_MAIN;
         busy_d = 1'b1;
      end else if (busy_q) begin
         if (carry) begin
            mode_d = pend_q;
            busy_d = 1'b0;
         end
      end else if (differ) begin
         if (need_wait) begin
            start  = 1'b1;
            pend_d = target;
            busy_d = 1'b1;
         end else begin
            mode_d = target;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= CLK_OFF;
         pend_q <= CLK_MAIN;
         busy_q <= 1'b1;
      end else begin
         mode_q <= mode_d;
         pend_q <= pend_d;
         busy_q <= busy_d;
      end
   end

   assign mode = mode_q;
   assign busy = busy_q;

   assert_off_means_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q == CLK_OFF |-> busy_q);

   assert_hold_during_wait_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !carry && !por_evt) |=> (busy_q && mode_q == $past(mode_q)));

   assert_wait_ends_on_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && carry && !por_evt) |=> !busy_q);

   assert_powerup_enters_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      por_evt |=> (mode_q == CLK_OFF && busy_q));

   assert_pll_exit_direct_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && !por_evt && mode_q == CLK_PLL && target != CLK_PLL)
      |=> (!busy_q && mode_q == $past(target)));

endmodule

// File: rtl/osc_settle_seq.sv
module osc_settle_seq
   import osc_settle_pkg::*;
#(
   parameter int unsigned CNT_W = 18,
   parameter int unsigned TAP0  = 9,
   parameter int unsigned TAP1  = 13,
   parameter int unsigned TAP2  = 15,
   parameter int unsigned TAP3  = 17
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rst_cause_vld,
   input  logic [CAUSE_W-1:0]   rst_cause,
   input  logic                 req_main,
   input  logic                 req_fast,
   input  logic                 tb_clr,
   input  logic [TAP_SEL_W-1:0] tap_sel,
   output logic [1:0]           clk_mode,
   output logic                 settling,
   output logic [CNT_W-1:0]     tb_count
);

   clk_mode_e mode_w;
   clk_mode_e target_w;
   logic      differ_w;
   logic      need_wait_w;
   logic      start_w;
   logic      carry_w;
   logic      por_evt;
   logic      busy_w;

   assign por_evt = rst_cause_vld && (rst_cause == CAUSE_POWERUP);

   osc_timebase #(
      .CNT_W (CNT_W),
      .TAP0  (TAP0),
      .TAP1  (TAP1),
      .TAP2  (TAP2),
      .TAP3  (TAP3)
   ) u_timebase (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (tb_clr || start_w),
      .tap_sel (tap_sel),
      .count   (tb_count),
      .carry   (carry_w)
   );

   osc_mode_plan u_plan (
      .active    (mode_w),
      .req_main  (req_main),
      .req_fast  (req_fast),
      .target    (target_w),
      .differ    (differ_w),
      .need_wait (need_wait_w)
   );

   osc_settle_ctl u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .por_evt   (por_evt),
      .carry     (carry_w),
      .target    (target_w),
      .differ    (differ_w),
      .need_wait (need_wait_w),
      .mode      (mode_w),
      .busy      (busy_w),
      .start     (start_w)
   );

   assign clk_mode = mode_w;
   assign settling = busy_w;

   assert_start_zeroes_count_R13: assert property (@(posedge clk) disable iff (!rst_n)
      start_w |=> (tb_count == '0 && settling));

   assert_other_causes_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_cause_vld && rst_cause != CAUSE_POWERUP && settling && !carry_w)
      |=> settling);

   assert_settle_on_leave_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!settling && !por_evt && (clk_mode == CLK_MAIN || clk_mode == CLK_SUB) && differ_w)
      |=> (settling && $stable(clk_mode)));

endmodule

// File: tb/osc_settle_seq_test.sv
module osc_settle_seq_test;

   localparam int CW = 10;
   localparam int MASK = (1 << CW) - 1;
   localparam logic [1:0] M_MAIN = 2'b00;
   localparam logic [1:0] M_PLL  = 2'b01;
   localparam logic [1:0] M_SUB  = 2'b10;
   localparam logic [1:0] M_OFF  = 2'b11;

   int taps [4] = '{2, 4, 6, 8};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rst_cause_vld = 1'b0;
   logic [2:0]    rst_cause = 3'd0;
   logic          req_main = 1'b1;
   logic          req_fast = 1'b1;
   logic          tb_clr = 1'b0;
   logic [1:0]    tap_sel = 2'd0;
   logic [1:0]    clk_mode;
   logic          settling;
   logic [CW-1:0] tb_count;

   int  total = 0;
   int  bad = 0;
   bit  done = 1'b0;

   always #4 clk = ~clk;

   osc_settle_seq #(
      .CNT_W (CW), .TAP0 (2), .TAP1 (4), .TAP2 (6), .TAP3 (8)
   ) uut (
      .clk (clk), .rst_n (rst_n), .rst_cause_vld (rst_cause_vld),
      .rst_cause (rst_cause), .req_main (req_main), .req_fast (req_fast),
      .tb_clr (tb_clr), .tap_sel (tap_sel), .clk_mode (clk_mode),
      .settling (settling), .tb_count (tb_count)
   );

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   // Drives a request at a falling edge and times the whole wait.
   task automatic run_wait(input string req, input logic m, input logic f, input logic [1:0] s,
                           input logic [1:0] old_m, input logic [1:0] new_m);
      int len;
      len = 1 << (taps[s] + 1);
      tap_sel = s; req_main = m; req_fast = f;
      step(1);
      chk(settling == 1'b1 && tb_count == 0, "R13", "start count", int'(tb_count), 0);
      step(len);
      chk(clk_mode == old_m && settling, req, "mode before end", int'(clk_mode), int'(old_m));
      step(1);
      chk(clk_mode == new_m && !settling, req, "mode after end", int'(clk_mode), int'(new_m));
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(clk_mode == M_OFF, "R1", "mode in reset", int'(clk_mode), int'(M_OFF));
      chk(settling == 1'b1 && tb_count == 0, "R1", "busy/count in reset", int'(tb_count), 0);
      tap_sel = 2'd0;
      rst_n = 1'b1;
      step(3);
      chk(tb_count == 3, "R2", "count after release", int'(tb_count), 3);
      step(5);
      chk(clk_mode == M_OFF && settling, "R5", "still waiting", int'(clk_mode), int'(M_OFF));
      step(1);
      chk(clk_mode == M_MAIN && !settling, "R5", "main after power-up", int'(clk_mode), int'(M_MAIN));
   endtask

   task automatic t_leave_pll(input logic m, input logic f, input logic [1:0] exp_m);
      int c0;
      c0 = int'(tb_count);
      req_main = m; req_fast = f;
      step(1);
      chk(clk_mode == exp_m && !settling, "R10", "direct switch", int'(clk_mode), int'(exp_m));
      chk(int'(tb_count) == ((c0 + 1) & MASK), "R10", "count kept", int'(tb_count), (c0 + 1) & MASK);
   endtask

   task automatic t_sub_to_pll_held();
      int len;
      len = 1 << (taps[0] + 1);
      tap_sel = 2'd0; req_main = 1'b0; req_fast = 1'b1;
      step(1);
      chk(settling == 1'b1, "R9", "wait started", int'(settling), 1);
      step(3);
      req_fast = 1'b0;
      step(len - 3);
      chk(clk_mode == M_SUB && settling, "R11", "held during wait", int'(clk_mode), int'(M_SUB));
      step(1);
      chk(clk_mode == M_PLL && !settling, "R9", "pll after wait", int'(clk_mode), int'(M_PLL));
      step(1);
      chk(clk_mode == M_SUB && !settling, "R11", "pending request applied", int'(clk_mode), int'(M_SUB));
   endtask

   task automatic t_warm_causes();
      for (int c = 1; c <= 6; c++) begin
         int c0;
         c0 = int'(tb_count);
         rst_cause = 3'(c); rst_cause_vld = 1'b1;
         step(1);
         rst_cause_vld = 1'b0;
         chk(clk_mode == M_MAIN && !settling, "R6", "mode after cause", int'(clk_mode), int'(M_MAIN));
         chk(int'(tb_count) == ((c0 + 1) & MASK), "R6", "count after cause", int'(tb_count), (c0 + 1) & MASK);
      end
   endtask

   task automatic t_powerup_cause();
      tap_sel = 2'd0; rst_cause = 3'd0; rst_cause_vld = 1'b1;
      step(1);
      rst_cause_vld = 1'b0;
      chk(clk_mode == M_OFF && settling && tb_count == 0, "R5", "power-up cause", int'(clk_mode), int'(M_OFF));
      step(8);
      chk(clk_mode == M_OFF && settling, "R5", "power-up wait", int'(clk_mode), int'(M_OFF));
      step(1);
      chk(clk_mode == M_MAIN && !settling, "R5", "main after cause", int'(clk_mode), int'(M_MAIN));
   endtask

   task automatic t_clear_in_wait();
      tap_sel = 2'd0; req_main = 1'b0; req_fast = 1'b1;
      step(6);
      chk(tb_count == 5 && settling, "R7", "wait in progress", int'(tb_count), 5);
      tb_clr = 1'b1;
      step(1);
      tb_clr = 1'b0;
      chk(tb_count == 0, "R3", "cleared by strobe", int'(tb_count), 0);
      step(8);
      chk(clk_mode == M_MAIN && settling, "R12", "restarted wait", int'(clk_mode), int'(M_MAIN));
      step(1);
      chk(clk_mode == M_PLL && !settling, "R12", "end of restarted wait", int'(clk_mode), int'(M_PLL));
   endtask

   initial begin
      t_reset();
      run_wait("R7", 1'b0, 1'b1, 2'd0, M_MAIN, M_PLL);
      t_leave_pll(1'b1, 1'b1, M_MAIN);
      run_wait("R8", 1'b1, 1'b0, 2'd1, M_MAIN, M_SUB);
      t_sub_to_pll_held();
      run_wait("R4", 1'b1, 1'b1, 2'd3, M_SUB, M_MAIN);
      t_warm_causes();
      t_powerup_cause();
      t_clear_in_wait();
      t_leave_pll(1'b1, 1'b0, M_SUB);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog (all requirements): actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule